// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Control

This peripheral holds two 16-bit down-counting interval timers and a shared interrupt controller behind an 8-bit register bus. A host selects a register with an 8-bit address. Only the low four address bits are decoded, so the sixteen registers repeat across the whole 256-byte window. Each timer has a 16-bit reload latch that is written one byte at a time. It also has a control register that starts or stops it, picks one-shot or continuous mode, and can force an immediate reload.

While a timer runs, it decrements by one on every clock. After it reaches zero, the next clock is an underflow. On an underflow the timer raises its pending flag, reloads from its latch and, in one-shot mode, stops itself. The pending flags are combined with a host-programmed enable mask to drive an active-low interrupt request. Reading the interrupt register returns the flags and clears them in the same access.

Top module: `itimer_top`

## Requirements
- R1: After synchronous reset, both counters and both latches hold 0xFFFF, both control registers read 0x00, the interrupt mask and pending flags are zero, and irq_n is high.
- R2: Register selection uses only bus_addr[3:0]. Any address with the same low nibble reaches the same register.
- R3: A write to index 4 (timer A) or 6 (timer B) changes only that timer's latch low byte and never changes the counter.
- R4: A write to index 5 (A) or 7 (B) sets the latch high byte. If the timer's start bit is 0, the counter is loaded from the full new latch value. If the timer is running, the counter is left unchanged. Reading index 4/5 (A) or 6/7 (B) returns the live counter low/high byte.
- R5: A write to index 14 (A) or 15 (B) sets start from data bit 0 and one-shot from data bit 3. If data bit 4 is 1, the counter is loaded from the latch in that same write. Reading the index returns start in bit 0 and one-shot in bit 3, with all other bits 0.
- R6: A running timer decrements once per clock. On the clock after it reads zero it underflows: it sets its pending flag (A on bit 0, B on bit 1) and reloads from its latch, giving a period of latch+1 clocks.
- R7: When the one-shot bit is 1, the start bit clears on underflow and the counter holds the reloaded value. When the one-shot bit is 0, the timer keeps running and underflows repeatedly.
- R8: Reading index 13 returns the pending flags in bits 1:0. Bit 7 is 1 when any flag is set and also enabled in the mask, and bits 6:2 are 0. The read then clears the flags.
- R9: A write to index 13 with data bit 7 set ORs data bits 1:0 into the mask. With bit 7 clear, it clears those mask bits.
- R10: irq_n is low exactly when some pending flag is set and its mask bit is also set.
- R11: An underflow in the same clock as a read-clear of index 13 leaves that timer's flag set for the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address; low nibble decoded |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; qualifies read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets three corner cases. The first is a read-clear of the interrupt register that lands on the same clock as an underflow. A design that lets the clear win would drop that flag, so irq_n would rise when it should stay low. The second is a high-byte write while the timer runs. A design that loads the counter unconditionally would make the counter jump to the new high byte. The third is exact one-shot timing. An off-by-one in the zero detection would move the irq_n fall one clock early or late, and a one-shot that does not stop would keep counting after the reload. Mask set and clear writes, and mirrored addresses, are also checked through irq_n and read data.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int IDX_W  = 4;
    localparam int NT     = 2;

    localparam logic [IDX_W-1:0] IDX_ICR    = 4'd13;
    localparam int               CTL_START  = 0;
    localparam int               CTL_ONESH  = 3;
    localparam int               CTL_FORCE  = 4;
    localparam int               ICR_SETCLR = 7;

    typedef struct packed {
        logic oneshot;
        logic start;
    } tmr_ctl_t;

    typedef struct packed {
        logic lo_wr;
        logic hi_wr;
        logic ctl_wr;
    } tmr_wr_t;

    function automatic logic [IDX_W-1:0] lo_idx(input int t);
        return IDX_W'(4 + 2 * t);
    endfunction

    function automatic logic [IDX_W-1:0] hi_idx(input int t);
        return IDX_W'(5 + 2 * t);
    endfunction

    function automatic logic [IDX_W-1:0] ctl_idx(input int t);
        return IDX_W'(14 + t);
    endfunction

    function automatic logic [DATA_W-1:0] ctl_byte(input tmr_ctl_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[CTL_START] = c.start;
        b[CTL_ONESH] = c.oneshot;
        return b;
    endfunction

endpackage

// File: rtl/itimer_counter.sv
module itimer_counter
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tmr_wr_t           wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output tmr_ctl_t          ctl,
    output logic              underflow
);

    logic [DATA_W-1:0] lat_lo, lat_hi;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lat_next;
    logic              force_ld, hi_ld;

    // Latch value including the byte written in this cycle
    assign lat_next = {wr.hi_wr ? wdata : lat_hi, wr.lo_wr ? wdata : lat_lo};
    assign force_ld = wr.ctl_wr && wdata[CTL_FORCE];
    assign hi_ld    = wr.hi_wr && !ctl.start;
    assign underflow = ctl.start && (cnt_q == '0) && !force_ld;
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo <= '1;
            lat_hi <= '1;
            cnt_q  <= '1;
            ctl    <= '0;
        end else begin
            if (wr.lo_wr) lat_lo <= wdata;
            if (wr.hi_wr) lat_hi <= wdata;

            if (force_ld || hi_ld)
                cnt_q <= lat_next;
            else if (underflow)
                cnt_q <= {lat_hi, lat_lo};
            else if (ctl.start)
                cnt_q <= cnt_q - 1'b1;

            if (wr.ctl_wr) begin
                ctl.start   <= wdata[CTL_START];
                ctl.oneshot <= wdata[CTL_ONESH];
            end else if (underflow && ctl.oneshot) begin
                ctl.start <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/itimer_irq.sv
module itimer_irq
    import itimer_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          icr_wr,
    input  logic          icr_rd,
    input  logic          setclr,
    input  logic [NT-1:0] bits,
    input  logic [NT-1:0] uf,
    output logic [NT-1:0] flags,
    output logic [NT-1:0] mask,
    output logic          active,
    output logic          irq_n
);

    assign active = |(flags & mask);
    assign irq_n  = !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '0;
        end else begin
            // New underflows survive a coincident read-clear
            if (icr_rd) flags <= uf;
            else        flags <= flags | uf;

            if (icr_wr) begin
                if (setclr) mask <= mask | bits;
                else        mask <= mask & ~bits;
            end
        end
    end

endmodule

// File: rtl/itimer_top.sv
module itimer_top
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);

    logic [IDX_W-1:0]          idx;
    logic [7-IDX_W:0]          unused_addr_hi;
    logic [NT-1:0][CNT_W-1:0]  cnt;
    tmr_ctl_t [NT-1:0]         ctl;
    logic [NT-1:0]             uf;
    logic [NT-1:0]             irq_flags, irq_mask;
    logic                      irq_active;
    logic [DATA_W-1:0]         status;

    assign idx            = bus_addr[IDX_W-1:0];
    assign unused_addr_hi = bus_addr[7:IDX_W];

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        tmr_wr_t sel;
        assign sel.lo_wr  = bus_wr && (idx == lo_idx(t));
        assign sel.hi_wr  = bus_wr && (idx == hi_idx(t));
        assign sel.ctl_wr = bus_wr && (idx == ctl_idx(t));

        itimer_counter u_cnt (
            .clk       (clk),
            .rst       (rst),
            .wr        (sel),
            .wdata     (bus_wdata),
            .count     (cnt[t]),
            .ctl       (ctl[t]),
            .underflow (uf[t])
        );
    end

    itimer_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .icr_wr (bus_wr && (idx == IDX_ICR)),
        .icr_rd (bus_rd && (idx == IDX_ICR)),
        .setclr (bus_wdata[ICR_SETCLR]),
        .bits   (bus_wdata[NT-1:0]),
        .uf     (uf),
        .flags  (irq_flags),
        .mask   (irq_mask),
        .active (irq_active),
        .irq_n  (irq_n)
    );

    assign status = {irq_active, {(DATA_W-1-NT){1'b0}}, irq_flags};

    always_comb begin
        bus_rdata = '0;
        for (int t = 0; t < NT; t++) begin
            if (idx == lo_idx(t))  bus_rdata = cnt[t][DATA_W-1:0];
            if (idx == hi_idx(t))  bus_rdata = cnt[t][CNT_W-1:DATA_W];
            if (idx == ctl_idx(t)) bus_rdata = ctl_byte(ctl[t]);
        end
        if (idx == IDX_ICR) bus_rdata = status;
    end

endmodule

// File: rtl/itimer_chk.sv
module itimer_chk
    import itimer_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [7:0]               bus_addr,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic                     irq_n,
    input logic [NT-1:0][CNT_W-1:0] cnt,
    input tmr_ctl_t [NT-1:0]        ctl,
    input logic [NT-1:0]            uf,
    input logic [NT-1:0]            irq_flags,
    input logic [NT-1:0]            irq_mask
);

    logic [IDX_W-1:0] a;
    assign a = bus_addr[IDX_W-1:0];

    for (genvar t = 0; t < NT; t++) begin : g_a
        p_lo_keeps_count_r3: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && a == lo_idx(t)) |=> $stable(cnt[t]));

        p_hi_loads_stopped_r4: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && a == hi_idx(t) && !ctl[t].start)
            |=> cnt[t][CNT_W-1:DATA_W] == $past(bus_wdata));

        p_decrement_r6: assert property (@(posedge clk) disable iff (rst)
            (ctl[t].start && cnt[t] != '0 && !bus_wr)
            |=> cnt[t] == CNT_W'($past(cnt[t]) - 1'b1));

        p_uf_sets_flag_r6: assert property (@(posedge clk) disable iff (rst)
            uf[t] |=> irq_flags[t]);

        p_oneshot_stops_r7: assert property (@(posedge clk) disable iff (rst)
            (uf[t] && ctl[t].oneshot && !(bus_wr && a == ctl_idx(t)))
            |=> !ctl[t].start);
    end

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && a == IDX_ICR && uf == '0) |=> irq_flags == '0);

    p_mask_set_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a == IDX_ICR && bus_wdata[ICR_SETCLR])
        |=> (irq_mask & $past(bus_wdata[NT-1:0])) == $past(bus_wdata[NT-1:0]));

    p_mask_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a == IDX_ICR && !bus_wdata[ICR_SETCLR])
        |=> (irq_mask & $past(bus_wdata[NT-1:0])) == '0);

    p_no_irq_unmasked_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> irq_n);

    p_collision_keeps_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && a == IDX_ICR && uf != '0) |=> (irq_flags & $past(uf)) == $past(uf));

endmodule

bind itimer_top itimer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .irq_n     (irq_n),
    .cnt       (cnt),
    .ctl       (ctl),
    .uf        (uf),
    .irq_flags (irq_flags),
    .irq_mask  (irq_mask)
);

// File: tb/itimer_top_tb.sv
module itimer_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    itimer_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    // {is_read, addr, data/expected, requirement number}
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'h04, 8'h34, 4'd3},   // R3 low latch byte only
        {1'b1, 8'h04, 8'hFF, 4'd3},   // R3 counter untouched
        {1'b0, 8'h05, 8'h12, 4'd4},   // R4 stopped: load 0x1234
        {1'b1, 8'h04, 8'h34, 4'd4},
        {1'b1, 8'h05, 8'h12, 4'd4},
        {1'b0, 8'h06, 8'h05, 4'd3},
        {1'b0, 8'h07, 8'h00, 4'd4},
        {1'b1, 8'h06, 8'h05, 4'd4},
        {1'b0, 8'h04, 8'h78, 4'd3},
        {1'b0, 8'h0E, 8'h10, 4'd5},   // R5 force load, stays stopped
        {1'b1, 8'h24, 8'h78, 4'd2},   // R2 mirrored low byte
        {1'b1, 8'h0E, 8'h00, 4'd5},   // R5 force bit not stored
        {1'b1, 8'h0D, 8'h00, 4'd8},
        {1'b1, 8'hF5, 8'h12, 4'd2}    // R2 mirrored high byte
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(bus_rdata, exp, req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_nc(input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h04, 8'hFF, "R1"); rd(8'h05, 8'hFF, "R1");
        rd(8'h06, 8'hFF, "R1"); rd(8'h07, 8'hFF, "R1");
        rd(8'h0E, 8'h00, "R1"); rd(8'h0F, 8'h00, "R1");
        rd(8'h0D, 8'h00, "R1");
        check({7'b0, irq_n}, 8'h01, "R1");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) rd(VEC[i][19:12], VEC[i][11:4], $sformatf("R%0d row %0d", VEC[i][3:0], i));
            else            wr(VEC[i][19:12], VEC[i][11:4]);
        end

        // R7 one-shot on timer B with latch 3: underflow on 4th clock
        wr(8'h06, 8'h03); wr(8'h07, 8'h00);
        wr(8'h0D, 8'h82);
        wr(8'h0F, 8'h09);
        repeat (3) @(negedge clk);
        check({7'b0, irq_n}, 8'h01, "R6 period not yet");
        @(negedge clk);
        check({7'b0, irq_n}, 8'h00, "R6 underflow at latch+1");
        repeat (6) @(negedge clk);
        rd(8'h07, 8'h00, "R7 one-shot held");
        rd(8'h06, 8'h03, "R7 reloaded and held");
        rd(8'h0F, 8'h08, "R7 start cleared");
        rd(8'h0D, 8'h82, "R8");
        check({7'b0, irq_n}, 8'h01, "R8 cleared");
        rd(8'h0D, 8'h00, "R8");

        // R6 continuous timer A with latch 2
        wr(8'h04, 8'h02); wr(8'h05, 8'h00);
        wr(8'h0E, 8'h01);
        rd(8'h04, 8'h02, "R6");
        rd(8'h04, 8'h01, "R6");
        rd(8'h04, 8'h00, "R6");
        rd(8'h04, 8'h02, "R6 reload");
        check({7'b0, irq_n}, 8'h01, "R10 masked flag");
        repeat (10) @(negedge clk);
        rd(8'h0D, 8'h01, "R7 continuous");
        wr(8'h05, 8'h40);
        rd(8'h05, 8'h00, "R4 running no load");
        wr(8'h0E, 8'h00);

        // R11 read-clear coinciding with underflow
        wr(8'h05, 8'h00);
        rd_nc(8'h0D);
        wr(8'h0D, 8'h81);
        wr(8'h0E, 8'h01);
        repeat (2) @(negedge clk);
        rd(8'h0D, 8'h00, "R11 before underflow");
        check({7'b0, irq_n}, 8'h00, "R11 flag kept");
        rd(8'h0D, 8'h81, "R11");
        repeat (5) @(negedge clk);
        wr(8'h0E, 8'h00);
        check({7'b0, irq_n}, 8'h00, "R10 pending and enabled");
        wr(8'h0D, 8'h01);
        check({7'b0, irq_n}, 8'h01, "R9 mask clear");
        wr(8'h0D, 8'h81);
        check({7'b0, irq_n}, 8'h00, "R9 mask set");
        rd(8'h0D, 8'h81, "R8");
        check({7'b0, irq_n}, 8'h01, "R10 after clear");

        finish_run();
    end

endmodule